// File: doc/BRIEF.md
# Histogram Dual Threshold Generator

This block produces the two thresholds used by a hysteresis edge classifier. It
gathers a per-frame histogram of 8-bit gradient-magnitude samples. When the last
sample of a frame arrives, it steps through the bins in ascending order and keeps
a running cumulative count. The high threshold is the first bin value at which
that running count covers the configured share of the frame. The share is 100
minus the high-percentage parameter, so by default 80% of the pixels lie at or
below the high threshold. The low threshold is then a fixed percentage of the
high one: 40% by default, rounded down.

The defaults assume a 512 by 512 frame. Samples arrive with a valid flag. The
block counts accepted samples to locate the end of each frame, so it needs no
end-of-frame marker. While it scans, it writes each bin back to zero, which leaves
the histogram empty for the next frame. After reset, a separate pass clears every
bin. The previous pair of thresholds stays on the outputs until a one-cycle done
pulse presents the new pair.

Top module: `thr_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `thr_hi`, `thr_lo` and `done` are all zero. For the first 2^MAG_W cycles after reset, a clearing pass runs, and samples offered during it are not counted.
- R2: A frame consists of exactly FRAME_W*FRAME_H samples taken on cycles with `in_valid` high. Cycles with `in_valid` low add nothing to the histogram or to the frame length.
- R3: `thr_hi` is the smallest value b for which the number of frame samples with magnitude ≤ b is at least ceil(N*(100-HI_PCT)/100), where N = FRAME_W*FRAME_H.
- R4: `thr_lo` equals floor(`thr_hi`*LO_PCT/100).
- R5: `done` goes high for exactly one cycle. It is driven at the 2^MAG_W-th rising edge after the edge that accepts the frame's last sample.
- R6: `thr_hi` and `thr_lo` keep their previous values in every cycle where `done` is low. They change only together with `done`.
- R7: Samples offered while the bins are being scanned are ignored. They affect neither the current result nor the next frame's result.
- R8: Every frame's thresholds depend only on that frame's samples, because all bins are back at zero before the next frame starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_mag` in this cycle |
| in_mag | input | MAG_W | Gradient magnitude sample |
| thr_hi | output | MAG_W | High threshold of the last completed frame |
| thr_lo | output | MAG_W | Low threshold of the last completed frame |
| done | output | 1 | One-cycle strobe when a new threshold pair is presented |

## Verification
The bench builds the block with 3-bit magnitudes (eight bins), a 4 by 4 frame (16 pixels), and the default 20% and 40% settings. With these values, each frame's full histogram and cumulative count can be recomputed in the bench.

At this size, the cumulative target falls at 13 of 16 samples. Some frames reach the target exactly at the lowest bin, and others miss it by one sample, which pushes the threshold to the top bin. Saturated frames (all zeros, all sevens), ramps and scattered patterns test the selection against every boundary. Every low threshold is compared with a direct integer division.

Junk samples are injected during the reset clearing pass and during every scan. Frames follow one another directly, so any leftover count would show up in the next frame's result.

// File: rtl/thr_pkg.sv
package thr_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_ACC   = 2'd1,
        ST_WALK  = 2'd2
    } thr_state_e;

    // Cumulative count a frame of npix pixels must reach at the high threshold.
    function automatic int unsigned cdf_target(input int unsigned npix,
                                               input int unsigned hi_pct);
        return (npix * (100 - hi_pct) + 99) / 100;
    endfunction

    // Fixed-point multiplier for a percentage, rounded up.
    function automatic int unsigned pct_mul(input int unsigned pct,
                                            input int unsigned shift);
        return (pct * (32'd1 << shift) + 99) / 100;
    endfunction

endpackage

// File: rtl/thr_hist_ram.sv
module thr_hist_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 19
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/thr_lo_scale.sv
module thr_lo_scale #(
    parameter int MAG_W  = 8,
    parameter int LO_PCT = 40
) (
    input  logic [MAG_W-1:0] hi,
    output logic [MAG_W-1:0] lo
);
    import thr_pkg::*;

    localparam int          SHIFT  = 16;
    localparam int          PW     = MAG_W + SHIFT + 2;
    localparam int unsigned LO_MUL = pct_mul(LO_PCT, SHIFT);

    logic [PW-1:0] prod;

    always_comb begin
        prod = PW'(hi) * PW'(LO_MUL);
        lo   = prod[SHIFT +: MAG_W];
    end
endmodule

// File: rtl/thr_gen.sv
module thr_gen #(
    parameter int MAG_W   = 8,
    parameter int FRAME_W = 512,
    parameter int FRAME_H = 512,
    parameter int HI_PCT  = 20,
    parameter int LO_PCT  = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [MAG_W-1:0] in_mag,
    output logic [MAG_W-1:0] thr_hi,
    output logic [MAG_W-1:0] thr_lo,
    output logic             done
);
    import thr_pkg::*;

    localparam int          NBINS  = 1 << MAG_W;
    localparam int          NPIX   = FRAME_W * FRAME_H;
    localparam int          CNT_W  = $clog2(NPIX + 1);
    localparam int unsigned TARGET = cdf_target(NPIX, HI_PCT);

    thr_state_e       state;
    logic [MAG_W-1:0] idx;
    logic [CNT_W-1:0] pix_cnt;
    logic [CNT_W-1:0] cum;
    logic             found;
    logic [MAG_W-1:0] hi_found;
    logic             walking;

    logic             ram_we;
    logic [MAG_W-1:0] ram_waddr;
    logic [MAG_W-1:0] ram_raddr;
    logic [CNT_W-1:0] ram_wdata;
    logic [CNT_W-1:0] ram_rdata;

    logic [CNT_W-1:0] cum_next;
    logic             hit;
    logic [MAG_W-1:0] hi_sel;
    logic [MAG_W-1:0] lo_sel;

    assign walking = (state == ST_WALK);

    always_comb begin
        ram_raddr = walking ? idx : in_mag;
        ram_we    = 1'b0;
        ram_waddr = idx;
        ram_wdata = '0;
        unique case (state)
            ST_CLEAR: ram_we = 1'b1;
            ST_WALK:  ram_we = 1'b1;
            ST_ACC: begin
                ram_we    = in_valid;
                ram_waddr = in_mag;
                ram_wdata = ram_rdata + 1'b1;
            end
            default: ram_we = 1'b0;
        endcase
    end

    thr_hist_ram #(.ADDR_W(MAG_W), .DATA_W(CNT_W)) u_ram (
        .clk  (clk),
        .we   (ram_we),
        .waddr(ram_waddr),
        .wdata(ram_wdata),
        .raddr(ram_raddr),
        .rdata(ram_rdata)
    );

    always_comb begin
        cum_next = cum + ram_rdata;
        hit      = !found && (32'(cum_next) >= TARGET);
        hi_sel   = found ? hi_found : idx;
    end

    thr_lo_scale #(.MAG_W(MAG_W), .LO_PCT(LO_PCT)) u_lo (
        .hi(hi_sel),
        .lo(lo_sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_CLEAR;
            idx      <= '0;
            pix_cnt  <= '0;
            cum      <= '0;
            found    <= 1'b0;
            hi_found <= '0;
            thr_hi   <= '0;
            thr_lo   <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_CLEAR: begin
                    idx <= idx + 1'b1;
                    if (idx == MAG_W'(NBINS - 1)) state <= ST_ACC;
                end
                ST_ACC: begin
                    if (in_valid) begin
                        if (pix_cnt == CNT_W'(NPIX - 1)) begin
                            pix_cnt <= '0;
                            idx     <= '0;
                            cum     <= '0;
                            found   <= 1'b0;
                            state   <= ST_WALK;
                        end else begin
                            pix_cnt <= pix_cnt + 1'b1;
                        end
                    end
                end
                ST_WALK: begin
                    cum <= cum_next;
                    idx <= idx + 1'b1;
                    if (hit) begin
                        found    <= 1'b1;
                        hi_found <= idx;
                    end
                    if (idx == MAG_W'(NBINS - 1)) begin
                        thr_hi <= hi_sel;
                        thr_lo <= lo_sel;
                        done   <= 1'b1;
                        state  <= ST_ACC;
                    end
                end
                default: state <= ST_CLEAR;
            endcase
        end
    end
endmodule

// File: rtl/thr_gen_chk.sv
module thr_gen_chk #(
    parameter int MAG_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             done,
    input logic             walking,
    input logic [MAG_W-1:0] thr_hi,
    input logic [MAG_W-1:0] thr_lo
);
    localparam int NBINS = 1 << MAG_W;

    logic [MAG_W+1:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst)          wcnt <= '0;
        else if (walking) wcnt <= wcnt + 1'b1;
        else              wcnt <= '0;
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                   // R5
    AST_DONE_AFTER_WALK: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(walking));                                          // R5
    AST_WALK_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        walking |-> (wcnt < (MAG_W+2)'(NBINS)));                           // R5
    AST_HOLD_HI: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(thr_hi));                                        // R6
    AST_HOLD_LO: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(thr_lo));                                        // R6
    AST_LO_NOT_ABOVE_HI: assert property (@(posedge clk) disable iff (rst)
        thr_lo <= thr_hi);                                                 // R4
endmodule

bind thr_gen thr_gen_chk #(.MAG_W(MAG_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .done   (done),
    .walking(walking),
    .thr_hi (thr_hi),
    .thr_lo (thr_lo)
);

// File: tb/thr_gen_bench.sv
module thr_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAG_W   = 3;
    localparam int FRAME_W = 4;
    localparam int FRAME_H = 4;
    localparam int HI_PCT  = 20;
    localparam int LO_PCT  = 40;
    localparam int NBINS   = 1 << MAG_W;
    localparam int NPIX    = FRAME_W * FRAME_H;
    localparam int NPAT    = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [MAG_W-1:0] in_mag = '0;
    logic [MAG_W-1:0] thr_hi;
    logic [MAG_W-1:0] thr_lo;
    logic             done;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    thr_gen #(.MAG_W(MAG_W), .FRAME_W(FRAME_W), .FRAME_H(FRAME_H),
              .HI_PCT(HI_PCT), .LO_PCT(LO_PCT)) u_thr_gen (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mag(in_mag),
        .thr_hi(thr_hi), .thr_lo(thr_lo), .done(done)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sample(input int pat, input int i);
        case (pat)
            0: return 0;
            1: return NBINS - 1;
            2: return i % NBINS;
            3: return (i * 3 + 1) % NBINS;
            4: return i / 2;
            5: return (i < 13) ? 0 : NBINS - 1;
            6: return (i < 12) ? 0 : NBINS - 1;
            7: return (i * i + 5) % NBINS;
            8: return (NPIX - 1 - i) / 2;
            default: return (i < 12) ? 2 : 5;
        endcase
    endfunction

    function automatic int exp_hi(input int pat);
        int hist [NBINS];
        int cum = 0;
        int target = (NPIX * (100 - HI_PCT) + 99) / 100;
        for (int b = 0; b < NBINS; b++) hist[b] = 0;
        for (int i = 0; i < NPIX; i++) hist[sample(pat, i)]++;
        for (int b = 0; b < NBINS; b++) begin
            cum += hist[b];
            if (cum >= target) return b;
        end
        return NBINS - 1;
    endfunction

    initial begin
        int prev_hi = 0;
        int prev_lo = 0;
        int lat;
        int hi_e;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 thr_hi in reset", int'(thr_hi), 0);
        check("R1 thr_lo in reset", int'(thr_lo), 0);
        check("R1 done in reset", int'(done), 0);
        rst = 1'b0;
        // R1: samples during the clearing pass are not counted
        in_valid = 1'b1;
        in_mag = 3'd7;
        repeat (NBINS) @(negedge clk);
        in_valid = 1'b0;
        check("R1 done after clear", int'(done), 0);
        check("R1 thr_hi after clear", int'(thr_hi), 0);

        for (int pat = 0; pat < NPAT; pat++) begin
            // R2: frame with idle gaps between samples
            for (int i = 0; i < NPIX; i++) begin
                if (i % 3 == 2) begin
                    in_valid = 1'b0;
                    in_mag = 3'd7;
                    @(negedge clk);
                end
                in_valid = 1'b1;
                in_mag = MAG_W'(sample(pat, i));
                @(negedge clk);
                if (done) check("R5 no early done", 1, 0);
            end
            // R7: junk offered during the scan
            in_valid = 1'b1;
            in_mag = MAG_W'(NBINS - 1);
            lat = 0;
            while (!done && lat < 4 * NBINS) begin
                // R6: previous pair held while waiting
                if (int'(thr_hi) != prev_hi) check("R6 thr_hi held", int'(thr_hi), prev_hi);
                if (int'(thr_lo) != prev_lo) check("R6 thr_lo held", int'(thr_lo), prev_lo);
                @(negedge clk);
                lat++;
            end
            in_valid = 1'b0;
            check("R5 done latency", lat, NBINS);
            hi_e = exp_hi(pat);
            check("R3 R8 thr_hi", int'(thr_hi), hi_e);
            check("R4 thr_lo", int'(thr_lo), hi_e * LO_PCT / 100);
            prev_hi = hi_e;
            prev_lo = hi_e * LO_PCT / 100;
            @(negedge clk);
            check("R5 done one cycle", int'(done), 0);
            check("R6 thr_hi after done", int'(thr_hi), prev_hi);
        end
        // R7: a frame right after junk still matches its own content
        for (int i = 0; i < NPIX; i++) begin
            in_valid = 1'b1;
            in_mag = MAG_W'(sample(6, i));
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (NBINS) @(negedge clk);
        check("R7 R8 thr_hi final frame", int'(thr_hi), exp_hi(6));
        check("R5 done final frame", int'(done), 1);

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule